// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block decodes one instruction from a six-byte window. The window holds the bytes fetched at the current program counter. The upper nibble of the first byte is the operation code and the lower nibble is the function code. From the operation code alone the block works out how long the instruction is (1, 2, 5 or 6 bytes). It also decides whether a register-specifier byte is present and whether a 32-bit little-endian constant is present. If the constant is present, the block also decides where it starts in the window.

The block returns:

- the two 4-bit register identifiers;
- the assembled constant;
- an illegal-instruction flag;
- the address of the next sequential instruction.

Register identifier 8 is the reserved "no register" code. The block drives it on both register outputs when the instruction has no register byte.

The decode logic is purely combinational. An optional output stage, selected by a parameter and enabled by default, registers all outputs together so the block can sit in a pipeline stage. Fetching, execution and write-back belong to other blocks.

Top module: `ivd_decoder`

Operation codes used throughout:

| Code | Class |
|------|-------|
| 0x0 | no-op |
| 0x1 | stop |
| 0x2 | register-to-register move |
| 0x3 | immediate-to-register move |
| 0x4 | register-to-memory store |
| 0x5 | memory-to-register load |
| 0x6 | arithmetic/logic |
| 0x7 | conditional branch |
| 0x8 | subroutine call |
| 0x9 | subroutine return |
| 0xA | stack push |
| 0xB | stack pop |

## Requirements
- R1: `icode_o` equals bits [7:4] of window byte 0 and `ifun_o` equals bits [3:0]. Byte 0 is `win_i[7:0]`, and byte k is `win_i[8k+7:8k]`.
- R2: `len_o` is set by the operation code. It is 1 for codes 0x0, 0x1 and 0x9, and for any code above 0xB. It is 2 for codes 0x2, 0x6, 0xA and 0xB. It is 5 for codes 0x7 and 0x8. It is 6 for codes 0x3, 0x4 and 0x5.
- R3: When a register byte is present, `ra_o` is bits [7:4] of window byte 1 and `rb_o` is bits [3:0] of it. This applies to codes 0x2 through 0x6, 0xA and 0xB, and `has_regs_o` is then 1. For every other code, `has_regs_o` is 0 and both `ra_o` and `rb_o` read 8.
- R4: For codes 0x3, 0x4 and 0x5, `const_o` is window bytes 2..5 assembled little-endian, with byte 2 as the least significant byte. For example, bytes cd ab 00 00 give 0x0000abcd.
- R5: For codes 0x7 and 0x8, `const_o` is window bytes 1..4 assembled little-endian. For all other codes, `const_o` is 0. `has_const_o` is 1 exactly for codes 0x3, 0x4, 0x5, 0x7 and 0x8.
- R6: `illegal_o` is 1 for any operation code above 0xB.
- R7: `illegal_o` is 1 when the function code is out of range for its class. Code 0x6 accepts 0–3, code 0x7 accepts 0–6, and every other defined code accepts only 0. In all other cases `illegal_o` is 0.
- R8: `next_pc_o` equals `pc_i` plus the decoded length, modulo 2^32.
- R9: With the output stage enabled, every output shows the decode of the inputs sampled at the previous rising clock edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| pc_i | input | 32 | Address of window byte 0 |
| win_i | input | 48 | Fetched bytes; byte k at bits [8k+7:8k] |
| icode_o | output | 4 | Operation code |
| ifun_o | output | 4 | Function code |
| len_o | output | 3 | Instruction length in bytes |
| ra_o | output | 4 | First register identifier, 8 when absent |
| rb_o | output | 4 | Second register identifier, 8 when absent |
| has_regs_o | output | 1 | Register byte present |
| has_const_o | output | 1 | Constant word present |
| const_o | output | 32 | Little-endian constant, 0 when absent |
| illegal_o | output | 1 | Undefined operation or function code |
| next_pc_o | output | 32 | Address of the next sequential instruction |

## Verification
The assertions take `pc_i` and `win_i` to be at known 0/1 values on every sampled clock edge while `rst_n` is high. The register-stage property further assumes that the inputs seen at one edge are what the output stage captured at that edge.

The bench meets these assumptions as follows:

- It drives fully defined words from time zero.
- It changes inputs only at the falling edge.
- It fills the bytes an instruction does not use with nonzero patterns, so that a wrongly chosen byte shows up in the outputs.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;
  localparam logic [NIB_W-1:0] NO_REG = 4'h8;

  // operation codes
  localparam logic [NIB_W-1:0] OPC_NOP    = 4'h0;
  localparam logic [NIB_W-1:0] OPC_STOP   = 4'h1;
  localparam logic [NIB_W-1:0] OPC_MOV_RR = 4'h2;
  localparam logic [NIB_W-1:0] OPC_MOV_IR = 4'h3;
  localparam logic [NIB_W-1:0] OPC_STORE  = 4'h4;
  localparam logic [NIB_W-1:0] OPC_LOAD   = 4'h5;
  localparam logic [NIB_W-1:0] OPC_ALU    = 4'h6;
  localparam logic [NIB_W-1:0] OPC_BRANCH = 4'h7;
  localparam logic [NIB_W-1:0] OPC_CALL   = 4'h8;
  localparam logic [NIB_W-1:0] OPC_RETURN = 4'h9;
  localparam logic [NIB_W-1:0] OPC_PUSH   = 4'hA;
  localparam logic [NIB_W-1:0] OPC_POP    = 4'hB;
  localparam logic [NIB_W-1:0] OPC_LAST   = OPC_POP;

  localparam logic [NIB_W-1:0] ALU_FN_MAX    = 4'h3;
  localparam logic [NIB_W-1:0] BRANCH_FN_MAX = 4'h6;

  // byte layout shapes of an instruction
  typedef enum logic [1:0] {
    SHP_LONE   = 2'd0,  // opcode byte only
    SHP_REGS   = 2'd1,  // opcode + register byte
    SHP_TARGET = 2'd2,  // opcode + 4-byte word
    SHP_FULL   = 2'd3   // opcode + register byte + 4-byte word
  } shape_e;

  function automatic shape_e shape_of(input logic [NIB_W-1:0] opc);
    shape_e s;
    case (opc)
      OPC_MOV_RR, OPC_ALU, OPC_PUSH, OPC_POP: s = SHP_REGS;
      OPC_MOV_IR, OPC_STORE, OPC_LOAD:        s = SHP_FULL;
      OPC_BRANCH, OPC_CALL:                   s = SHP_TARGET;
      default:                                s = SHP_LONE;
    endcase
    return s;
  endfunction

  function automatic logic [LEN_W-1:0] shape_len(input shape_e s);
    logic [LEN_W-1:0] n;
    case (s)
      SHP_REGS:   n = 3'd2;
      SHP_TARGET: n = 3'd5;
      SHP_FULL:   n = 3'd6;
      default:    n = 3'd1;
    endcase
    return n;
  endfunction

  function automatic logic shape_has_regs(input shape_e s);
    return (s == SHP_REGS) || (s == SHP_FULL);
  endfunction

  function automatic logic shape_has_word(input shape_e s);
    return (s == SHP_TARGET) || (s == SHP_FULL);
  endfunction

  function automatic logic fn_allowed(input logic [NIB_W-1:0] opc,
                                      input logic [NIB_W-1:0] fn);
    logic ok;
    if (opc > OPC_LAST)         ok = 1'b0;
    else if (opc == OPC_ALU)    ok = (fn <= ALU_FN_MAX);
    else if (opc == OPC_BRANCH) ok = (fn <= BRANCH_FN_MAX);
    else                        ok = (fn == '0);
    return ok;
  endfunction

  function automatic logic [31:0] advance_pc(input logic [31:0] pc,
                                             input logic [LEN_W-1:0] n);
    return pc + {{(32-LEN_W){1'b0}}, n};
  endfunction

endpackage

// File: rtl/ivd_head_split.sv
module ivd_head_split
  import ivd_pkg::*;
(
  input  logic [BYTE_W-1:0] head_i,
  output logic [NIB_W-1:0]  opc_o,
  output logic [NIB_W-1:0]  fn_o
);
  assign opc_o = head_i[BYTE_W-1:NIB_W];
  assign fn_o  = head_i[NIB_W-1:0];
endmodule

// File: rtl/ivd_class_decode.sv
module ivd_class_decode
  import ivd_pkg::*;
(
  input  logic [NIB_W-1:0] opc_i,
  input  logic [NIB_W-1:0] fn_i,
  output logic [LEN_W-1:0] len_o,
  output logic             has_regs_o,
  output logic             has_word_o,
  output logic             word_at1_o,
  output logic             illegal_o
);
  shape_e shp;

  always_comb begin
    shp        = shape_of(opc_i);
    len_o      = shape_len(shp);
    has_regs_o = shape_has_regs(shp);
    has_word_o = shape_has_word(shp);
    word_at1_o = (shp == SHP_TARGET);
    illegal_o  = !fn_allowed(opc_i, fn_i);
  end
endmodule

// File: rtl/ivd_field_extract.sv
module ivd_field_extract
  import ivd_pkg::*;
#(
  parameter int WIN_BYTES = 6,
  parameter int WORD_W    = 32
) (
  input  logic [WIN_BYTES*BYTE_W-1:0] win_i,
  input  logic                        has_regs_i,
  input  logic                        has_word_i,
  input  logic                        word_at1_i,
  output logic [NIB_W-1:0]            ra_o,
  output logic [NIB_W-1:0]            rb_o,
  output logic [WORD_W-1:0]           word_o
);
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int REG_BYTE   = 1;

  logic [BYTE_W-1:0] regbyte;
  logic [WORD_W-1:0] word_raw;

  assign regbyte = win_i[REG_BYTE*BYTE_W +: BYTE_W];

  // constant starts right after the opcode byte or after the register byte
  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_word_byte
    assign word_raw[i*BYTE_W +: BYTE_W] = word_at1_i
        ? win_i[(i+1)*BYTE_W +: BYTE_W]
        : win_i[(i+2)*BYTE_W +: BYTE_W];
  end

  assign ra_o   = has_regs_i ? regbyte[BYTE_W-1:NIB_W] : NO_REG;
  assign rb_o   = has_regs_i ? regbyte[NIB_W-1:0]      : NO_REG;
  assign word_o = has_word_i ? word_raw : '0;
endmodule

// File: rtl/ivd_next_pc.sv
module ivd_next_pc
  import ivd_pkg::*;
(
  input  logic [31:0]      pc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [31:0]      next_pc_o
);
  assign next_pc_o = advance_pc(pc_i, len_i);
endmodule

// File: rtl/ivd_decoder.sv
module ivd_decoder
  import ivd_pkg::*;
#(
  parameter int  WIN_BYTES = 6,
  parameter int  WORD_W    = 32,
  parameter bit  REG_OUT   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [31:0]                 pc_i,
  input  logic [WIN_BYTES*BYTE_W-1:0] win_i,
  output logic [NIB_W-1:0]            icode_o,
  output logic [NIB_W-1:0]            ifun_o,
  output logic [LEN_W-1:0]            len_o,
  output logic [NIB_W-1:0]            ra_o,
  output logic [NIB_W-1:0]            rb_o,
  output logic                        has_regs_o,
  output logic                        has_const_o,
  output logic [WORD_W-1:0]           const_o,
  output logic                        illegal_o,
  output logic [31:0]                 next_pc_o
);
  // combinational decode results, named for the checker
  logic [NIB_W-1:0]  c_opc, c_fn, c_ra, c_rb;
  logic [LEN_W-1:0]  c_len;
  logic              c_has_regs, c_has_word, c_word_at1, c_illegal;
  logic [WORD_W-1:0] c_word;
  logic [31:0]       c_next_pc;

  ivd_head_split u_head (
    .head_i (win_i[BYTE_W-1:0]),
    .opc_o  (c_opc),
    .fn_o   (c_fn)
  );

  ivd_class_decode u_class (
    .opc_i      (c_opc),
    .fn_i       (c_fn),
    .len_o      (c_len),
    .has_regs_o (c_has_regs),
    .has_word_o (c_has_word),
    .word_at1_o (c_word_at1),
    .illegal_o  (c_illegal)
  );

  ivd_field_extract #(.WIN_BYTES(WIN_BYTES), .WORD_W(WORD_W)) u_fields (
    .win_i      (win_i),
    .has_regs_i (c_has_regs),
    .has_word_i (c_has_word),
    .word_at1_i (c_word_at1),
    .ra_o       (c_ra),
    .rb_o       (c_rb),
    .word_o     (c_word)
  );

  ivd_next_pc u_npc (
    .pc_i      (pc_i),
    .len_i     (c_len),
    .next_pc_o (c_next_pc)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        icode_o     <= '0;
        ifun_o      <= '0;
        len_o       <= '0;
        ra_o        <= '0;
        rb_o        <= '0;
        has_regs_o  <= 1'b0;
        has_const_o <= 1'b0;
        const_o     <= '0;
        illegal_o   <= 1'b0;
        next_pc_o   <= '0;
      end else begin
        icode_o     <= c_opc;
        ifun_o      <= c_fn;
        len_o       <= c_len;
        ra_o        <= c_ra;
        rb_o        <= c_rb;
        has_regs_o  <= c_has_regs;
        has_const_o <= c_has_word;
        const_o     <= c_word;
        illegal_o   <= c_illegal;
        next_pc_o   <= c_next_pc;
      end
    end
  end else begin : g_comb
    assign icode_o     = c_opc;
    assign ifun_o      = c_fn;
    assign len_o       = c_len;
    assign ra_o        = c_ra;
    assign rb_o        = c_rb;
    assign has_regs_o  = c_has_regs;
    assign has_const_o = c_has_word;
    assign const_o     = c_word;
    assign illegal_o   = c_illegal;
    assign next_pc_o   = c_next_pc;
  end
endmodule

// File: rtl/ivd_decoder_chk.sv
module ivd_decoder_chk #(
  parameter int WORD_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       pc_i,
  input logic [3:0]        c_opc,
  input logic [3:0]        c_fn,
  input logic [2:0]        c_len,
  input logic [3:0]        c_ra,
  input logic [3:0]        c_rb,
  input logic              c_has_regs,
  input logic              c_has_word,
  input logic              c_illegal,
  input logic [WORD_W-1:0] c_word,
  input logic [31:0]       c_next_pc,
  input logic [2:0]        len_o,
  input logic [31:0]       next_pc_o
);
  logic [31:0] step;
  assign step = c_next_pc - pc_i;

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (c_len == 3'd1) || (c_len == 3'd2) || (c_len == 3'd5) || (c_len == 3'd6)); // R2

  AST_NO_REGS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !c_has_regs |-> (c_ra == 4'h8) && (c_rb == 4'h8)); // R3

  AST_NO_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !c_has_word |-> (c_word == '0)); // R5

  AST_HIGH_OPC_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_opc > 4'hB) |-> c_illegal); // R6

  AST_BRANCH_FN_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (c_opc == 4'h7) && (c_fn <= 4'h6) |-> !c_illegal); // R7

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (step >= 32'd1) && (step <= 32'd6)); // R8

  if (REG_OUT) begin : g_pipe
    AST_STAGE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (len_o == $past(c_len)) && (next_pc_o == $past(c_next_pc))); // R9
  end
endmodule

bind ivd_decoder ivd_decoder_chk #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_i       (pc_i),
  .c_opc      (c_opc),
  .c_fn       (c_fn),
  .c_len      (c_len),
  .c_ra       (c_ra),
  .c_rb       (c_rb),
  .c_has_regs (c_has_regs),
  .c_has_word (c_has_word),
  .c_illegal  (c_illegal),
  .c_word     (c_word),
  .c_next_pc  (c_next_pc),
  .len_o      (len_o),
  .next_pc_o  (next_pc_o)
);

// File: tb/test_ivd_decoder.sv
module test_ivd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic [47:0] win_i = '0;
  logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
  logic [2:0]  len_o;
  logic        has_regs_o, has_const_o, illegal_o;
  logic [31:0] const_o, next_pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ivd_decoder i_ivd_decoder (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .win_i(win_i),
    .icode_o(icode_o), .ifun_o(ifun_o), .len_o(len_o),
    .ra_o(ra_o), .rb_o(rb_o), .has_regs_o(has_regs_o),
    .has_const_o(has_const_o), .const_o(const_o),
    .illegal_o(illegal_o), .next_pc_o(next_pc_o)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [47:0] win;   // byte 0 in [7:0]
    logic [2:0]  len;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [31:0] k;
    logic        ill;
    logic        hr;
    logic        hk;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0000, 48'h0000_abcd_8230, 3'd6, 4'h8, 4'h2, 32'h0000_abcd, 1'b0, 1'b1, 1'b1},
    '{32'h0000_0006, 48'hffff_ffff_4520, 3'd2, 4'h4, 4'h5, 32'h0,         1'b0, 1'b1, 1'b0},
    '{32'h0000_0100, 48'hffff_fff4_1550, 3'd6, 4'h1, 4'h5, 32'hffff_fff4, 1'b0, 1'b1, 1'b1},
    '{32'h0000_0010, 48'hff00_0000_2880, 3'd5, 4'h8, 4'h8, 32'h0000_0028, 1'b0, 1'b0, 1'b1},
    '{32'h0000_0020, 48'haa12_3456_7876, 3'd5, 4'h8, 4'h8, 32'h1234_5678, 1'b0, 1'b0, 1'b1},
    '{32'h0000_0024, 48'h0000_0000_0077, 3'd5, 4'h8, 4'h8, 32'h0,         1'b1, 1'b0, 1'b1},
    '{32'h0000_0030, 48'h1234_5678_0163, 3'd2, 4'h0, 4'h1, 32'h0,         1'b0, 1'b1, 1'b0},
    '{32'h0000_0032, 48'h1234_5678_0164, 3'd2, 4'h0, 4'h1, 32'h0,         1'b1, 1'b1, 1'b0},
    '{32'h0000_0040, 48'h1122_3344_5500, 3'd1, 4'h8, 4'h8, 32'h0,         1'b0, 1'b0, 1'b0},
    '{32'h0000_0041, 48'h1122_3344_5510, 3'd1, 4'h8, 4'h8, 32'h0,         1'b0, 1'b0, 1'b0},
    '{32'h0000_0042, 48'h1122_3344_5590, 3'd1, 4'h8, 4'h8, 32'h0,         1'b0, 1'b0, 1'b0},
    '{32'h0000_0043, 48'h1122_3344_5591, 3'd1, 4'h8, 4'h8, 32'h0,         1'b1, 1'b0, 1'b0},
    '{32'h0000_0050, 48'h7777_7777_28a0, 3'd2, 4'h2, 4'h8, 32'h0,         1'b0, 1'b1, 1'b0},
    '{32'h0000_0052, 48'h7777_7777_38b0, 3'd2, 4'h3, 4'h8, 32'h0,         1'b0, 1'b1, 1'b0},
    '{32'h0000_0060, 48'h9999_9999_99c0, 3'd1, 4'h8, 4'h8, 32'h0,         1'b1, 1'b0, 1'b0},
    '{32'h0000_0061, 48'h9999_9999_99f5, 3'd1, 4'h8, 4'h8, 32'h0,         1'b1, 1'b0, 1'b0},
    '{32'h0000_0070, 48'h0000_041c_6440, 3'd6, 4'h6, 4'h4, 32'h0000_041c, 1'b0, 1'b1, 1'b1},
    '{32'hffff_fffe, 48'h0000_abcd_8230, 3'd6, 4'h8, 4'h2, 32'h0000_abcd, 1'b0, 1'b1, 1'b1},
    '{32'h0000_0080, 48'h5555_5555_5501, 3'd1, 4'h8, 4'h8, 32'h0,         1'b1, 1'b0, 1'b0},
    '{32'h0000_0090, 48'hdead_beef_3352, 3'd6, 4'h3, 4'h3, 32'hdead_beef, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] pc, input logic [47:0] w);
    @(negedge clk);
    pc_i  = pc;
    win_i = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    pc_i  = 32'h1234_5678;
    win_i = 48'h0000_abcd_8230;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset len",     {29'd0, len_o},     32'd0);
    check("R9 reset const",   const_o,            32'd0);
    check("R9 reset next_pc", next_pc_o,          32'd0);
    check("R9 reset ra/rb",   {24'd0, ra_o, rb_o}, 32'd0);
    check("R9 reset flags",   {29'd0, has_regs_o, has_const_o, illegal_o}, 32'd0);
    rst_n = 1'b1;

    // vector walk
    for (int n = 0; n < NV; n++) begin
      apply(VEC[n].pc, VEC[n].win);
      check("R1 opcode",    {28'd0, icode_o}, {28'd0, VEC[n].win[7:4]});
      check("R1 function",  {28'd0, ifun_o},  {28'd0, VEC[n].win[3:0]});
      check("R2 length",    {29'd0, len_o},   {29'd0, VEC[n].len});
      check("R3 ra",        {28'd0, ra_o},    {28'd0, VEC[n].ra});
      check("R3 rb",        {28'd0, rb_o},    {28'd0, VEC[n].rb});
      check("R3 has_regs",  {31'd0, has_regs_o}, {31'd0, VEC[n].hr});
      check("R4/R5 const",  const_o,          VEC[n].k);
      check("R5 has_const", {31'd0, has_const_o}, {31'd0, VEC[n].hk});
      check("R6/R7 illegal", {31'd0, illegal_o}, {31'd0, VEC[n].ill});
      check("R8 next_pc",   next_pc_o,        VEC[n].pc + {29'd0, VEC[n].len});
    end

    // R6: every code above 0xB flagged, with length 1
    for (int c = 12; c < 16; c++) begin
      apply(32'h200, {40'h0102_0304_05, 4'(c), 4'h0});
      check("R6 high code illegal", {31'd0, illegal_o}, 32'd1);
      check("R2 high code length",  {29'd0, len_o},     32'd1);
    end

    // R7: branch function boundary 6 legal, 7..15 illegal; ALU 3 legal, 4 illegal
    for (int f = 0; f < 16; f++) begin
      apply(32'h300, {40'h0, 4'h7, 4'(f)});
      check("R7 branch function", {31'd0, illegal_o}, (f > 6) ? 32'd1 : 32'd0);
    end
    for (int f = 0; f < 16; f++) begin
      apply(32'h300, {40'h0, 4'h6, 4'(f)});
      check("R7 alu function", {31'd0, illegal_o}, (f > 3) ? 32'd1 : 32'd0);
    end

    // R9: output holds previous decode until the next rising edge
    apply(32'h400, 48'h0000_0000_0000);
    @(negedge clk);
    pc_i  = 32'h500;
    win_i = 48'h0000_abcd_8230;
    #1;
    check("R9 hold before edge", {29'd0, len_o}, 32'd1);
    check("R9 hold next_pc",     next_pc_o,      32'h401);
    @(posedge clk);
    @(negedge clk);
    check("R9 update after edge", {29'd0, len_o}, 32'd6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule